// File: doc/BRIEF.md
# Display Control Bus Master

This block lets a host CPU talk to up to sixteen small peripheral devices over a byte-wide display control bus. The host programs a mode register, and that one register defines a transfer. It sets how many bytes move per data word, which slave is addressed, which of the slave's eight control registers is selected (with optional advance after every byte), the byte order, the acknowledge style, and the chip-select setup, active and hold times in clock cycles.

A host write to the data register starts a write transfer that sends the word out one byte at a time. A host read of the data register starts a read transfer. The host is held off with a wait signal until the bytes have been gathered, and the assembled word is then returned. A status register reports whether a transfer is in flight. It also has a sticky flag that records when an asynchronous acknowledge never arrived.

The host port is a simple select/write strobe with a combinational wait. An access that meets a busy bus is held, not dropped. Register offsets are 0 for mode, 1 for data and 2 for status.

Top module: `dcb_master`

## Requirements
- R1: After reset, chip select is high, the status register reads 0 and the mode register reads 0.
- R2: Bytes per data word: 4 when mode bit 2 (pack) is set; otherwise mode bits [1:0], where 1, 2 and 3 give that many bytes and 0 gives four.
- R3: Byte k of a transfer uses bits [31-8k -: 8] of the data word. When mode bit 28 (swap) is set it uses bits [8k +: 8] instead. A read places each received byte in the same lane, and lanes not transferred read as 0.
- R4: Without acknowledge, the first strobe follows the accepting edge after exactly setup (bits [27:23]) cycles with chip select high. Each strobe lasts width+1 cycles (width in bits [17:13]). Between strobes of one transfer, chip select stays high for hold (bits [22:18]) plus setup cycles, and never fewer than one.
- R5: With mode bit 3 set, the control-register select (bits [6:4], driven on `dcb_sel`) advances by one modulo 8 after each byte, and the new value reads back from the mode register. With bit 3 clear it stays fixed.
- R6: During a strobe, `dcb_slave` carries mode bits [10:7]. `dcb_we` is 1 for a write transfer and 0 for a read transfer.
- R7: Status bit 4 reads 1 while a transfer is in progress and 0 once it has ended.
- R8: A host write of the data or mode register while busy raises `host_wait` until the bus is idle. A data write held this way is then performed, not lost.
- R9: A host read of the data register holds `host_wait` high until its read transfer completes, and then returns the assembled word.
- R10: With mode bit 11 set and bit 12 clear, a strobe ends on the first clock edge at which `dcb_ack` is high, whatever the width field says.
- R11: With mode bit 12 set, `dcb_ack` passes through a two-stage synchronizer and a strobe ends on its synchronized rising edge. An acknowledge present in the strobe's first cycle gives a 3-cycle strobe.
- R12: With mode bit 12 set, a strobe that sees no acknowledge for 255 cycles ends the transfer without sending the remaining bytes, and sets status bit 5. Bit 5 then stays set until reset.
- R13: A reset during a transfer returns chip select high and clears busy by the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access request, held until `host_wait` is low at a clock edge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset: 0 mode, 1 data, 2 status |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid when `host_wait` is low |
| host_wait | output | 1 | Stall for the current host access |
| dcb_cs_n | output | 1 | Chip select, active low |
| dcb_we | output | 1 | Bus direction, 1 = write |
| dcb_slave | output | 4 | Slave address |
| dcb_sel | output | 3 | Control-register select |
| dcb_dout | output | 8 | Byte driven to the slave |
| dcb_din | input | 8 | Byte returned by the slave |
| dcb_ack | input | 1 | Slave acknowledge |

## Verification
The bench measures chip-select lead, strobe length and inter-strobe gap on every strobe. A design that counts setup or width off by one, or lets zero setup and zero hold run two strobes together, shows up as a wrong measured length. Byte order is checked in both directions, with and without swap, and with partial widths. A design that fills read lanes from the wrong end or leaves stale bytes in lanes that were not transferred returns a wrong word. The select wrap from 7 to 0, back-to-back writes that must stall rather than drop, and an asynchronous acknowledge that never comes are all driven. Each of these catches a different failure: a lost second word, a bus hung waiting on a missing acknowledge, or a timeout flag that clears itself. A reset in the middle of a strobe must leave chip select released.

// File: rtl/dcbm_pkg.sv
package dcbm_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int IDX_W  = $clog2(LANES);
    localparam int TIME_W = 5;

    // Host-visible mode layout; field positions are part of the programming model.
    typedef struct packed {
        logic              swap;       // [28]
        logic [TIME_W-1:0] setup;      // [27:23]
        logic [TIME_W-1:0] hold;       // [22:18]
        logic [TIME_W-1:0] width;      // [17:13]
        logic              ack_async;  // [12]
        logic              ack_sync;   // [11]
        logic [3:0]        slave;      // [10:7]
        logic [2:0]        sel;        // [6:4]
        logic              auto_inc;   // [3]
        logic              pack;       // [2]
        logic [1:0]        size;       // [1:0]
    } dcb_mode_t;

    localparam int MODE_W = $bits(dcb_mode_t);

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
    } dcb_phase_t;

    typedef enum logic [1:0] {
        ACK_NONE, ACK_SYNC, ACK_ASYNC
    } ack_kind_t;

    localparam logic [1:0] HR_MODE   = 2'd0;
    localparam logic [1:0] HR_DATA   = 2'd1;
    localparam logic [1:0] HR_STATUS = 2'd2;

    localparam int ST_BUSY_BIT = 4;
    localparam int ST_TMO_BIT  = 5;

    function automatic ack_kind_t ack_kind(input logic sync_en, input logic async_en);
        if (async_en)     return ACK_ASYNC;
        else if (sync_en) return ACK_SYNC;
        else              return ACK_NONE;
    endfunction

    function automatic logic [IDX_W:0] byte_total(input logic pack, input logic [1:0] size);
        if (pack || size == 2'd0) return (IDX_W+1)'(LANES);
        else                      return (IDX_W+1)'(size);
    endfunction

endpackage

// File: rtl/dcbm_ack_sync.sv
module dcbm_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_in,
    output logic ack_rise
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], ack_in};
            last_q <= chain[STAGES-1];
        end
    end

    assign ack_rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/dcbm_timing.sv
module dcbm_timing
    import dcbm_pkg::*;
#(
    parameter int TMO_LIMIT = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] t_setup,
    input  logic [TIME_W-1:0] t_hold,
    input  logic [TIME_W-1:0] t_width,
    input  ack_kind_t         kind,
    input  logic [IDX_W:0]    nbytes,
    input  logic              ack_raw,
    input  logic              ack_rise,
    output dcb_phase_t        phase,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              byte_end,
    output logic              abort,
    output logic              done
);
    localparam int TMO_W = $clog2(TMO_LIMIT + 1);

    logic [TIME_W-1:0] cnt;
    logic [TMO_W-1:0]  tmo_cnt;
    logic              strobe_hit;
    logic              last_byte;

    always_comb begin
        case (kind)
            ACK_SYNC:  strobe_hit = ack_raw;
            ACK_ASYNC: strobe_hit = ack_rise;
            default:   strobe_hit = (cnt == '0);
        endcase
    end

    assign last_byte = ({1'b0, byte_idx} == nbytes - (IDX_W+1)'(1));
    assign byte_end  = (phase == PH_STROBE) && strobe_hit;
    assign abort     = (phase == PH_STROBE) && !strobe_hit && (kind == ACK_ASYNC)
                       && (tmo_cnt == TMO_W'(TMO_LIMIT - 1));
    assign done      = abort
                     || (byte_end && last_byte && t_hold == '0)
                     || (phase == PH_HOLD && cnt == '0 && last_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            tmo_cnt  <= '0;
            byte_idx <= '0;
        end else begin
            if (phase != PH_STROBE) tmo_cnt <= '0;
            case (phase)
                PH_IDLE: begin
                    byte_idx <= '0;
                    if (start) begin
                        if (t_setup != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= t_setup - TIME_W'(1);
                        end else begin
                            phase <= PH_STROBE;
                            cnt   <= t_width;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= t_width;
                    end else begin
                        cnt <= cnt - TIME_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (byte_end) begin
                        tmo_cnt <= '0;
                        if (t_hold != '0) begin
                            phase <= PH_HOLD;
                            cnt   <= t_hold - TIME_W'(1);
                        end else if (last_byte) begin
                            phase <= PH_IDLE;
                        end else begin
                            // zero hold: setup alone forms the gap, at least one cycle
                            byte_idx <= byte_idx + IDX_W'(1);
                            phase    <= PH_SETUP;
                            cnt      <= (t_setup != '0) ? t_setup - TIME_W'(1) : '0;
                        end
                    end else if (abort) begin
                        phase   <= PH_IDLE;
                        tmo_cnt <= '0;
                    end else begin
                        if (kind == ACK_ASYNC) tmo_cnt <= tmo_cnt + TMO_W'(1);
                        if (cnt != '0) cnt <= cnt - TIME_W'(1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        if (last_byte) begin
                            phase <= PH_IDLE;
                        end else begin
                            byte_idx <= byte_idx + IDX_W'(1);
                            if (t_setup != '0) begin
                                phase <= PH_SETUP;
                                cnt   <= t_setup - TIME_W'(1);
                            end else begin
                                phase <= PH_STROBE;
                                cnt   <= t_width;
                            end
                        end
                    end else begin
                        cnt <= cnt - TIME_W'(1);
                    end
                end
            endcase
        end
    end

    assert_strobe_len_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && kind == ACK_NONE && cnt != '0) |=> (phase == PH_STROBE));

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> ({1'b0, byte_idx} < nbytes));

    assert_tmo_bound_R12: assert property (@(posedge clk) disable iff (rst)
        tmo_cnt < TMO_W'(TMO_LIMIT));

endmodule

// File: rtl/dcbm_byte_path.sv
module dcbm_byte_path
    import dcbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic              swap,
    input  logic              capture,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic [WORD_W-1:0] rx_word
);
    logic [LANES-1:0][BYTE_W-1:0] tx_q;
    logic [LANES-1:0][BYTE_W-1:0] rx_q;
    logic [IDX_W-1:0]             lane;

    // natural order sends the most significant lane first
    assign lane = swap ? byte_idx : IDX_W'(LANES - 1) - byte_idx;
    assign dout = tx_q[lane];

    always_ff @(posedge clk) begin
        if (rst)       tx_q <= '0;
        else if (load) tx_q <= wr_word;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || load)                          rx_q[g] <= '0;
            else if (capture && lane == IDX_W'(g))    rx_q[g] <= din;
        end
    end

    assign rx_word = rx_q;

endmodule

// File: rtl/dcbm_host_if.sv
module dcbm_host_if
    import dcbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [MODE_W-1:0] host_mode_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_wait,
    input  logic              busy,
    input  logic              byte_end,
    input  logic              abort,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output dcb_mode_t         mode,
    output logic              start,
    output logic              dir_read
);
    logic tmo_flag;
    logic rd_ready;
    logic acc_data, acc_mode, start_wr, start_rd, take_rd, wr_mode;

    assign acc_data = host_sel && host_addr == HR_DATA;
    assign acc_mode = host_sel && host_addr == HR_MODE;
    assign start_wr = acc_data && host_we && !busy;
    assign start_rd = acc_data && !host_we && !busy && !rd_ready;
    assign take_rd  = acc_data && !host_we && !busy && rd_ready;
    assign wr_mode  = acc_mode && host_we && !busy;
    assign start    = start_wr || start_rd;

    assign host_wait = (acc_mode && host_we && busy)
                    || (acc_data && host_we && busy)
                    || (acc_data && !host_we && (busy || !rd_ready));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            tmo_flag <= 1'b0;
            rd_ready <= 1'b0;
            dir_read <= 1'b0;
        end else begin
            if (wr_mode)                        mode     <= dcb_mode_t'(host_mode_wdata);
            else if (byte_end && mode.auto_inc) mode.sel <= mode.sel + 3'd1;
            if (abort)                          tmo_flag <= 1'b1;
            if (start)                          dir_read <= start_rd;
            if (done && dir_read)               rd_ready <= 1'b1;
            else if (take_rd)                   rd_ready <= 1'b0;
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            HR_MODE:   host_rdata = {{(WORD_W-MODE_W){1'b0}}, mode};
            HR_DATA:   host_rdata = rx_word;
            HR_STATUS: begin
                host_rdata[ST_BUSY_BIT] = busy;
                host_rdata[ST_TMO_BIT]  = tmo_flag;
            end
            default:   host_rdata = '0;
        endcase
    end

    assert_tmo_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |=> tmo_flag);

    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(mode.setup) && $stable(mode.hold) && $stable(mode.width)
                  && $stable(mode.size) && $stable(mode.pack) && $stable(mode.slave)));

endmodule

// File: rtl/dcb_master.sv
module dcb_master
    import dcbm_pkg::*;
#(
    parameter int TMO_LIMIT   = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        host_wait,
    output logic        dcb_cs_n,
    output logic        dcb_we,
    output logic [3:0]  dcb_slave,
    output logic [2:0]  dcb_sel,
    output logic [7:0]  dcb_dout,
    input  logic [7:0]  dcb_din,
    input  logic        dcb_ack
);
    dcb_mode_t        mode;
    dcb_phase_t       phase;
    logic [IDX_W-1:0] byte_idx;
    logic             start, dir_read, busy;
    logic             byte_end, abort, done, ack_rise;
    logic [WORD_W-1:0] rx_word;

    assign busy = (phase != PH_IDLE);

    dcbm_host_if u_host (
        .clk, .rst, .host_sel, .host_we, .host_addr,
        .host_mode_wdata(host_wdata[MODE_W-1:0]),
        .host_rdata, .host_wait,
        .busy, .byte_end, .abort, .done, .rx_word,
        .mode, .start, .dir_read
    );

    dcbm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk, .rst, .ack_in(dcb_ack), .ack_rise
    );

    dcbm_timing #(.TMO_LIMIT(TMO_LIMIT)) u_timing (
        .clk, .rst, .start,
        .t_setup(mode.setup), .t_hold(mode.hold), .t_width(mode.width),
        .kind(ack_kind(mode.ack_sync, mode.ack_async)),
        .nbytes(byte_total(mode.pack, mode.size)),
        .ack_raw(dcb_ack), .ack_rise,
        .phase, .byte_idx, .byte_end, .abort, .done
    );

    dcbm_byte_path u_bytes (
        .clk, .rst, .load(start), .wr_word(host_wdata), .byte_idx,
        .swap(mode.swap), .capture(byte_end), .din(dcb_din),
        .dout(dcb_dout), .rx_word
    );

    assign dcb_cs_n  = (phase != PH_STROBE);
    assign dcb_we    = !dir_read;
    assign dcb_slave = mode.slave;
    assign dcb_sel   = mode.sel;

    assert_wait_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_we && host_addr == HR_DATA && busy) |-> host_wait);

endmodule

// File: tb/test_dcb_master.sv
module test_dcb_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait, dcb_cs_n, dcb_we, dcb_ack;
    logic [3:0]  dcb_slave;
    logic [2:0]  dcb_sel;
    logic [7:0]  dcb_dout, dcb_din;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    dcb_master i_dcb_master (.*);

    // ---- strobe monitor ----
    int  ns = 0, base = 0;
    bit  prev_low = 0;
    int  run = 0, gapc = 0;
    logic [7:0] m_byte[64];
    logic [2:0] m_sel[64];
    logic [3:0] m_slave[64];
    logic       m_we[64];
    int         m_len[64], m_gap[64];

    always @(negedge clk) begin
        if (!dcb_cs_n) begin
            if (!prev_low) begin
                m_byte[ns%64] = dcb_dout; m_sel[ns%64] = dcb_sel;
                m_slave[ns%64] = dcb_slave; m_we[ns%64] = dcb_we;
                m_gap[ns%64] = gapc; run = 1;
            end else run++;
            prev_low = 1;
        end else begin
            if (prev_low) begin m_len[ns%64] = run; ns++; gapc = 1; end
            else gapc++;
            prev_low = 0;
        end
    end

    // ---- slave model ----
    int  lowcnt = 0, ack_lat = 0;
    bit  ack_en = 0;
    int  rel;
    always @(posedge clk) lowcnt <= dcb_cs_n ? 0 : lowcnt + 1;
    assign dcb_ack = ack_en && !dcb_cs_n && (lowcnt >= ack_lat);
    assign rel = ns - base;
    assign dcb_din = {4'(rel + 1), 1'b0, dcb_sel};

    function automatic logic [31:0] mk_mode(int size, bit pack, bit inc, int sel, int slave,
                                            bit sack, bit aack, int width, int hold, int setup, bit swap);
        return {3'b0, swap, 5'(setup), 5'(hold), 5'(width), aack, sack,
                4'(slave), 3'(sel), inc, pack, 2'(size)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic host_acc(input bit we, input logic [1:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output bit waited);
        @(negedge clk);
        host_sel = 1; host_we = we; host_addr = addr; host_wdata = wd;
        waited = 0;
        #1;
        while (host_wait) begin waited = 1; @(negedge clk); #1; end
        rd = host_rdata;
        @(posedge clk); #1;
        host_sel = 0; host_we = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        logic [31:0] r; bit w;
        host_acc(1, a, d, r, w);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        bit w;
        host_acc(0, a, 32'h0, d, w);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        do rd_reg(2'd2, s); while (s[4]);
        repeat (2) @(negedge clk);
    endtask

    task automatic lead_count(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (dcb_cs_n) n++; else break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R1", "cs_n after reset", 32'(dcb_cs_n), 1);
        rd_reg(2'd2, r); chk("R1", "status after reset", r, 0);
        rd_reg(2'd0, r); chk("R1", "mode after reset", r, 0);
    endtask

    task automatic t_basic_write();
        int ld; logic [31:0] r;
        wr(2'd0, mk_mode(0, 0, 0, 3, 5, 0, 0, 0, 1, 2, 0));
        base = ns;
        wr(2'd1, 32'hA1B2C3D4);
        lead_count(ld);
        chk("R4", "setup lead", ld, 2);
        rd_reg(2'd2, r); chk("R7", "busy during transfer", r, 32'h10);
        wait_idle();
        chk("R2", "byte count size0", ns - base, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R3", "msb-first byte", m_byte[(base+k)%64], 32'(8'hA1 + 8'h11 * k));
            chk("R4", "strobe width+1", m_len[(base+k)%64], 1);
            chk("R6", "slave addr", m_slave[(base+k)%64], 5);
            chk("R6", "write dir", m_we[(base+k)%64], 1);
            chk("R5", "select fixed", m_sel[(base+k)%64], 3);
            if (k > 0) chk("R4", "gap hold+setup", m_gap[(base+k)%64], 3);
        end
        rd_reg(2'd2, r); chk("R7", "busy cleared", r, 0);
    endtask

    task automatic t_widths();
        wr(2'd0, mk_mode(1, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0));
        base = ns; wr(2'd1, 32'hA1B2C3D4); wait_idle();
        chk("R2", "size1 count", ns - base, 1);
        chk("R3", "size1 byte", m_byte[base%64], 8'hA1);
        wr(2'd0, mk_mode(3, 0, 0, 0, 1, 0, 0, 0, 1, 1, 0));
        base = ns; wr(2'd1, 32'hA1B2C3D4); wait_idle();
        chk("R2", "size3 count", ns - base, 3);
        chk("R3", "size3 last byte", m_byte[(base+2)%64], 8'hC3);
        wr(2'd0, mk_mode(1, 1, 0, 0, 1, 0, 0, 0, 1, 1, 0));
        base = ns; wr(2'd1, 32'hA1B2C3D4); wait_idle();
        chk("R2", "pack overrides size", ns - base, 4);
    endtask

    task automatic t_autoinc_swap();
        logic [31:0] r;
        wr(2'd0, mk_mode(0, 0, 1, 6, 2, 0, 0, 0, 0, 1, 1));
        base = ns; wr(2'd1, 32'hA1B2C3D4); wait_idle();
        for (int k = 0; k < 4; k++) begin
            chk("R5", "select advance", m_sel[(base+k)%64], 32'((6 + k) % 8));
            chk("R3", "swap order", m_byte[(base+k)%64], 32'(8'hD4 - 8'h11 * k));
        end
        rd_reg(2'd0, r); chk("R5", "select readback", 32'(r[6:4]), 2);
    endtask

    task automatic t_read();
        logic [31:0] r;
        wr(2'd0, mk_mode(3, 0, 0, 1, 9, 0, 0, 3, 1, 2, 0));
        base = ns; rd_reg(2'd1, r);
        chk("R9", "read word", r, 32'h11213100);
        chk("R3", "read lanes", ns - base, 3);
        chk("R6", "read dir", m_we[base%64], 0);
        chk("R4", "read strobe len", m_len[base%64], 4);
    endtask

    task automatic t_stall();
        logic [31:0] r; bit w;
        wr(2'd0, mk_mode(0, 0, 0, 0, 3, 0, 0, 0, 1, 2, 0));
        base = ns;
        wr(2'd1, 32'h01020304);
        host_acc(1, 2'd1, 32'h05060708, r, w);
        chk("R8", "second write waited", 32'(w), 1);
        host_acc(1, 2'd0, mk_mode(0, 0, 0, 0, 3, 0, 0, 0, 1, 2, 0), r, w);
        chk("R8", "mode write waited", 32'(w), 1);
        wait_idle();
        chk("R8", "both words sent", ns - base, 8);
        chk("R8", "second word last byte", m_byte[(base+7)%64], 8'h08);
    endtask

    task automatic t_sync_ack();
        ack_en = 1; ack_lat = 2;
        wr(2'd0, mk_mode(2, 0, 0, 0, 4, 1, 0, 7, 1, 1, 0));
        base = ns; wr(2'd1, 32'hCAFE0000); wait_idle();
        chk("R10", "sync strobe len", m_len[base%64], 3);
        chk("R10", "sync byte", m_byte[(base+1)%64], 8'hFE);
        ack_en = 0; ack_lat = 0;
    endtask

    task automatic t_async_ack();
        logic [31:0] r;
        ack_en = 1; ack_lat = 0;
        wr(2'd0, mk_mode(0, 0, 1, 2, 4, 0, 1, 0, 1, 1, 1));
        base = ns; rd_reg(2'd1, r);
        chk("R11", "async read word", r, 32'h45342312);
        chk("R11", "async strobe len", m_len[base%64], 3);
        chk("R11", "async byte count", ns - base, 4);
        ack_en = 0;
    endtask

    task automatic t_timeout();
        logic [31:0] r;
        ack_en = 0;
        wr(2'd0, mk_mode(0, 0, 0, 0, 4, 0, 1, 0, 1, 1, 0));
        base = ns; wr(2'd1, 32'h11223344); wait_idle();
        chk("R12", "abort after one byte", ns - base, 1);
        chk("R12", "timeout strobe len", m_len[base%64], 255);
        chk("R12", "cs released", 32'(dcb_cs_n), 1);
        rd_reg(2'd2, r); chk("R12", "timeout flag", r, 32'h20);
        wr(2'd0, mk_mode(1, 0, 0, 0, 4, 0, 0, 0, 1, 1, 0));
        wr(2'd1, 32'h99000000); wait_idle();
        rd_reg(2'd2, r); chk("R12", "flag sticky", r, 32'h20);
    endtask

    task automatic t_zero_gap();
        int ld;
        wr(2'd0, mk_mode(0, 0, 0, 0, 2, 0, 0, 1, 0, 0, 0));
        base = ns; wr(2'd1, 32'h55AA55AA);
        lead_count(ld);
        chk("R4", "zero setup lead", ld, 0);
        wait_idle();
        chk("R4", "zero gap count", ns - base, 4);
        chk("R4", "min gap", m_gap[(base+2)%64], 1);
        chk("R4", "width1 len", m_len[(base+1)%64], 2);
    endtask

    task automatic t_mid_reset();
        logic [31:0] r;
        wr(2'd0, mk_mode(0, 0, 0, 0, 2, 0, 0, 20, 0, 0, 0));
        wr(2'd1, 32'h12345678);
        repeat (3) @(negedge clk);
        chk("R13", "strobe active before reset", 32'(dcb_cs_n), 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R13", "cs high after reset", 32'(dcb_cs_n), 1);
        rd_reg(2'd2, r); chk("R13", "busy cleared by reset", r, 0);
        rd_reg(2'd0, r); chk("R13", "mode cleared by reset", r, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_basic_write();
        t_widths();
        t_autoinc_swap();
        t_read();
        t_stall();
        t_sync_ack();
        t_async_ack();
        t_zero_gap();
        t_timeout();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule